// File: doc/BRIEF.md
# Lockable General Configuration Register

This block holds the 32-bit general configuration word of a storage host controller function, plus a small bank of 8-bit capability pointer registers that firmware programs during boot. Every field has its own access behaviour. Some fields are plain read-write. Others accept only one write. One is a status bit that hardware sets and software clears by writing a 1. A function-disable bit, once set, stays set until the next platform reset.

Firmware sets a lock bit before it hands the system over. From then on the pointer registers hold their values, and any write to them is accepted silently without changing them. The block also watches for unsupported requests. Those that arrive on the primary interface are recorded and may be reported as a system error. Those that arrive over the sideband path are ignored.

Two synchronous resets act on the block. Platform reset clears everything. Function-level reset clears only the operating mode, the unsupported-request reporting state and the error outputs.

Top module: `hostctl_gencfg`

## Requirements
- R1: While `rst_plat` is high, and in the cycle after it, the following values hold: the configuration word reads 0, every pointer reads 0, `cfg_claim` is 1, and `sse_sts` and `serr_msg` are 0.
- R2: A write to address 0 changes only the byte lanes whose `wr_be` bit is 1. The plain read-write fields are bit 17 (error message disable), bit 16 (mode), bit 15, bits 14:12, bit 11 and bit 9 (unsupported-request reporting enable).
- R3: Byte lane 0 (bits 7:0, the size selects and ID selects) and bit 31 (lock) are write-once. In each of these two lanes, only the first write after platform reset that enables the lane takes effect. Any later write to that lane is ignored, whatever value it carries.
- R4: Addresses 1 to NPTR hold the pointer registers, which are written through lane 0. While bit 31 (lock) is 1, a write to a pointer leaves its value unchanged.
- R5: Writing 1 to bit 10 (function disable) sets it, and writing 0 does not clear it. Only platform reset clears it, not function-level reset. While it is set, `cfg_claim` is 0, reads return 0 and register writes are ignored.
- R6: Bit 8 is set by an unsupported request with `ur_sideband`=0. Software clears it by writing 1 to bit 8. If the hardware set and the clearing write happen in the same cycle, the bit ends up set.
- R7: An unsupported request with `ur_sideband`=1 sets no status bit and produces no message.
- R8: When bit 9 and `serr_en` are both 1, a primary unsupported request sets `sse_sts` and drives `serr_msg` high for exactly the next cycle. If either of the two is 0, neither happens.
- R9: When bit 17 is 1, the `serr_msg` pulse is suppressed, but `sse_sts` is still set.
- R10: Bits 30:18 always read 0, and writes to them have no effect.
- R11: Function-level reset clears bit 16, bit 9, bit 8, `sse_sts` and `serr_msg`. It leaves all other fields, the write-once state and the pointers unchanged.
- R12: A read of an address above NPTR returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_plat | input | 1 | Platform reset, synchronous, active high |
| rst_flr | input | 1 | Function-level reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 = config word, 1..NPTR = pointers) |
| wr_be | input | 4 | Byte lane enables |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational read data |
| ur_valid | input | 1 | Unsupported request seen this cycle |
| ur_sideband | input | 1 | 1 = request came over sideband, 0 = primary |
| serr_en | input | 1 | System-error enable from the command register |
| cfg_claim | output | 1 | Configuration accesses are claimed |
| sse_sts | output | 1 | Signaled system error status |
| serr_msg | output | 1 | One-cycle system error message pulse |

## Verification
The bench builds the block with NPTR=4 and PTR_W=8, which gives ADDR_W=3. With these values it reaches the first and the last pointer address, and also the unmapped addresses 5 to 7 that R12 covers. A single pass drives the block through the whole firmware sequence: programming, locking, reporting under several enable combinations, function-level reset, disable, and finally a platform reset that reopens the write-once lanes.

// File: rtl/hostctl_gencfg_pkg.sv
package hostctl_gencfg_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;

    localparam int unsigned B_LOCK   = 31;
    localparam int unsigned B_ERRDIS = 17;
    localparam int unsigned B_MODE   = 16;
    localparam int unsigned B_FDIS   = 10;
    localparam int unsigned B_RPT    = 9;
    localparam int unsigned B_URD    = 8;

    // plain read-write fields: 17,16,15,14:12,11,9
    localparam logic [WORD_W-1:0] RW_MASK  = 32'h0003_FA00;
    // write-once fields: lock and lane 0
    localparam logic [WORD_W-1:0] WO_MASK  = 32'h8000_00FF;
    localparam logic [LANES-1:0]  WO_LANES = 4'b1001;
    // fields cleared by function-level reset (besides status)
    localparam logic [WORD_W-1:0] FLR_MASK = 32'h0001_0200;

    typedef struct packed {
        logic        lock;
        logic [12:0] rsvd;
        logic        errdis;
        logic        mode;
        logic        dpar_en;
        logic [2:0]  wsize;
        logic        cpar_en;
        logic        fdis;
        logic        rpt_en;
        logic        urd;
        logic        alt_id;
        logic        id_sel;
        logic        flr_cap;
        logic [1:0]  msize;
        logic [2:0]  asize;
    } gencfg_t;

    function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [WORD_W-1:0] m;
        for (int j = 0; j < int'(LANES); j++) begin
            m[j*8 +: 8] = {8{be[j]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/hostctl_gencfg_regs.sv
module hostctl_gencfg_regs
    import hostctl_gencfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_plat,
    input  logic              rst_flr,
    input  logic              wr_hit,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              urd,
    output gencfg_t           cfg,
    output logic              urd_clr
);

    logic [WORD_W-1:0] q;
    logic [LANES-1:0]  wo_used;
    logic [WORD_W-1:0] nxt;
    logic [LANES-1:0]  wo_used_nxt;
    logic [WORD_W-1:0] lm;

    always_comb begin
        lm          = lane_mask(wr_be);
        nxt         = q;
        wo_used_nxt = wo_used;
        if (wr_hit) begin
            nxt = (nxt & ~(RW_MASK & lm)) | (wr_data & RW_MASK & lm);
            for (int j = 0; j < int'(LANES); j++) begin
                if (WO_LANES[j] && wr_be[j] && !wo_used[j]) begin
                    nxt[j*8 +: 8]  = wr_data[j*8 +: 8] & WO_MASK[j*8 +: 8];
                    wo_used_nxt[j] = 1'b1;
                end
            end
            if (wr_be[B_FDIS/8] && wr_data[B_FDIS]) begin
                nxt[B_FDIS] = 1'b1;
            end
        end
        if (rst_flr) begin
            nxt = nxt & ~FLR_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst_plat) begin
            q       <= '0;
            wo_used <= '0;
        end else begin
            q       <= nxt;
            wo_used <= wo_used_nxt;
        end
    end

    assign urd_clr = wr_hit && wr_be[B_URD/8] && wr_data[B_URD];

    always_comb begin
        cfg     = gencfg_t'(q);
        cfg.urd = urd;
    end

endmodule

// File: rtl/hostctl_gencfg_ptrs.sv
module hostctl_gencfg_ptrs #(
    parameter int unsigned NPTR  = 4,
    parameter int unsigned PTR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_plat,
    input  logic                       locked,
    input  logic [NPTR-1:0]            wr_stb,
    input  logic [PTR_W-1:0]           wr_val,
    output logic [NPTR-1:0][PTR_W-1:0] ptr_q
);

    for (genvar i = 0; i < int'(NPTR); i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst_plat) begin
                ptr_q[i] <= '0;
            end else if (wr_stb[i] && !locked) begin
                ptr_q[i] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/hostctl_gencfg_ur.sv
module hostctl_gencfg_ur (
    input  logic clk,
    input  logic rst_plat,
    input  logic rst_flr,
    input  logic ur_valid,
    input  logic ur_sideband,
    input  logic serr_en,
    input  logic rpt_en,
    input  logic errdis,
    input  logic urd_clr,
    output logic urd,
    output logic sse_sts,
    output logic serr_msg
);

    logic hit;
    logic report;

    assign hit    = ur_valid && !ur_sideband;
    assign report = hit && rpt_en && serr_en;

    always_ff @(posedge clk) begin
        if (rst_plat || rst_flr) begin
            urd      <= 1'b0;
            sse_sts  <= 1'b0;
            serr_msg <= 1'b0;
        end else begin
            serr_msg <= report && !errdis;
            if (hit) begin
                urd <= 1'b1;
            end else if (urd_clr) begin
                urd <= 1'b0;
            end
            if (report) begin
                sse_sts <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hostctl_gencfg.sv
module hostctl_gencfg
    import hostctl_gencfg_pkg::*;
#(
    parameter int unsigned NPTR   = 4,
    parameter int unsigned PTR_W  = 8,
    localparam int unsigned ADDR_W = $clog2(NPTR + 1)
) (
    input  logic              clk,
    input  logic              rst_plat,
    input  logic              rst_flr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              ur_valid,
    input  logic              ur_sideband,
    input  logic              serr_en,
    output logic              cfg_claim,
    output logic              sse_sts,
    output logic              serr_msg
);

    gencfg_t                    cfg;
    logic                       urd;
    logic                       urd_clr;
    logic                       cfg_hit;
    logic [NPTR-1:0]            ptr_stb;
    logic [NPTR-1:0][PTR_W-1:0] ptr_vec;

    assign cfg_claim = !cfg.fdis;
    assign cfg_hit   = wr_en && cfg_claim && (wr_addr == '0);

    always_comb begin
        for (int i = 0; i < int'(NPTR); i++) begin
            ptr_stb[i] = wr_en && cfg_claim && wr_be[0] && (wr_addr == ADDR_W'(i + 1));
        end
    end

    hostctl_gencfg_regs u_regs (
        .clk     (clk),
        .rst_plat(rst_plat),
        .rst_flr (rst_flr),
        .wr_hit  (cfg_hit),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .urd     (urd),
        .cfg     (cfg),
        .urd_clr (urd_clr)
    );

    hostctl_gencfg_ptrs #(.NPTR(NPTR), .PTR_W(PTR_W)) u_ptrs (
        .clk     (clk),
        .rst_plat(rst_plat),
        .locked  (cfg.lock),
        .wr_stb  (ptr_stb),
        .wr_val  (wr_data[PTR_W-1:0]),
        .ptr_q   (ptr_vec)
    );

    hostctl_gencfg_ur u_ur (
        .clk        (clk),
        .rst_plat   (rst_plat),
        .rst_flr    (rst_flr),
        .ur_valid   (ur_valid),
        .ur_sideband(ur_sideband),
        .serr_en    (serr_en),
        .rpt_en     (cfg.rpt_en),
        .errdis     (cfg.errdis),
        .urd_clr    (urd_clr),
        .urd        (urd),
        .sse_sts    (sse_sts),
        .serr_msg   (serr_msg)
    );

    always_comb begin
        rd_data = '0;
        if (cfg_claim) begin
            if (rd_addr == '0) begin
                rd_data = cfg;
            end
            for (int i = 0; i < int'(NPTR); i++) begin
                if (rd_addr == ADDR_W'(i + 1)) begin
                    rd_data = {{(WORD_W - PTR_W){1'b0}}, ptr_vec[i]};
                end
            end
        end
    end

endmodule

// File: rtl/hostctl_gencfg_chk.sv
module hostctl_gencfg_chk
    import hostctl_gencfg_pkg::*;
#(
    parameter int unsigned NPTR   = 4,
    parameter int unsigned PTR_W  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input logic                       clk,
    input logic                       rst_plat,
    input logic                       rst_flr,
    input gencfg_t                    cfg,
    input logic [NPTR-1:0][PTR_W-1:0] ptr_vec,
    input logic [ADDR_W-1:0]          rd_addr,
    input logic [WORD_W-1:0]          rd_data,
    input logic                       ur_valid,
    input logic                       ur_sideband,
    input logic                       serr_en,
    input logic                       cfg_claim,
    input logic                       sse_sts,
    input logic                       serr_msg
);

    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst_plat)
        cfg.lock |=> cfg.lock); // R3

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst_plat)
        cfg.lock |=> $stable(ptr_vec)); // R4

    AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (rst_plat)
        !cfg_claim |=> !cfg_claim); // R5

    AST_SIDEBAND_SILENT: assert property (@(posedge clk) disable iff (rst_plat || rst_flr)
        (ur_valid && ur_sideband && !cfg.urd) |=> !cfg.urd && !serr_msg); // R7

    AST_MSG_PULSE: assert property (@(posedge clk) disable iff (rst_plat || rst_flr)
        (ur_valid && !ur_sideband && cfg.rpt_en && serr_en && !cfg.errdis)
        |=> serr_msg && sse_sts); // R8

    AST_MSG_MUTED: assert property (@(posedge clk) disable iff (rst_plat || rst_flr)
        (ur_valid && !ur_sideband && cfg.rpt_en && serr_en && cfg.errdis)
        |=> !serr_msg && sse_sts); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst_plat)
        (rd_addr == '0) |-> (rd_data[30:18] == '0)); // R10

endmodule

bind hostctl_gencfg hostctl_gencfg_chk #(.NPTR(NPTR), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_plat   (rst_plat),
    .rst_flr    (rst_flr),
    .cfg        (cfg),
    .ptr_vec    (ptr_vec),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .ur_valid   (ur_valid),
    .ur_sideband(ur_sideband),
    .serr_en    (serr_en),
    .cfg_claim  (cfg_claim),
    .sse_sts    (sse_sts),
    .serr_msg   (serr_msg)
);

// File: tb/sim_hostctl_gencfg.sv
`timescale 1ns/1ps
module sim_hostctl_gencfg;

    localparam int NPTR   = 4;
    localparam int PTR_W  = 8;
    localparam int ADDR_W = $clog2(NPTR + 1);

    localparam int K_RD    = 0;
    localparam int K_CLAIM = 1;
    localparam int K_SSE   = 2;
    localparam int K_MSG   = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_plat = 1'b1;
    logic              rst_flr = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [3:0]        wr_be = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic              ur_valid = 1'b0;
    logic              ur_sideband = 1'b0;
    logic              serr_en = 1'b0;
    logic              cfg_claim;
    logic              sse_sts;
    logic              serr_msg;

    int    n_checks = 0;
    int    n_errors = 0;
    item_t q_exp[$];
    event  ev_sample;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    hostctl_gencfg #(.NPTR(NPTR), .PTR_W(PTR_W)) u0 (
        .clk(clk), .rst_plat(rst_plat), .rst_flr(rst_flr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ur_valid(ur_valid), .ur_sideband(ur_sideband), .serr_en(serr_en),
        .cfg_claim(cfg_claim), .sse_sts(sse_sts), .serr_msg(serr_msg)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(ev_sample);
            while (q_exp.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q_exp.pop_front();
                case (it.kind)
                    K_RD:    act = rd_data;
                    K_CLAIM: act = {31'b0, cfg_claim};
                    K_SSE:   act = {31'b0, sse_sts};
                    default: act = {31'b0, serr_msg};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int kind, input int addr, input logic [31:0] exp, input string req);
        item_t it;
        rd_addr = ADDR_W'(addr);
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        q_exp.push_back(it);
        #1;
        ->ev_sample;
        #1;
    endtask

    task automatic reg_wr(input int addr, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic ur_pulse(input logic sb, input logic se);
        @(negedge clk);
        ur_valid = 1'b1; ur_sideband = sb; serr_en = se;
        @(negedge clk);
        ur_valid = 1'b0; ur_sideband = 1'b0;
    endtask

    task automatic pulse_flr();
        @(negedge clk);
        rst_flr = 1'b1;
        @(negedge clk);
        rst_flr = 1'b0;
    endtask

    task automatic pulse_plat();
        @(negedge clk);
        rst_plat = 1'b1;
        @(negedge clk);
        rst_plat = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_plat = 1'b0; rst_flr = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_val(K_RD, 0, 32'h0, "R1 cfg");
        expect_val(K_RD, 1, 32'h0, "R1 ptr");
        expect_val(K_CLAIM, 0, 32'h1, "R1 claim");
        expect_val(K_SSE, 0, 32'h0, "R1 sse");
        expect_val(K_MSG, 0, 32'h0, "R1 msg");

        // R2 lanes 1 and 2 only; R10 reserved bits ignored
        reg_wr(0, 4'b0110, 32'hFFFB_FAFF);
        expect_val(K_RD, 0, 32'h0003_FA00, "R2/R10 lane write");

        // R3 write-once lane 0
        reg_wr(0, 4'b0001, 32'h0000_005A);
        expect_val(K_RD, 0, 32'h0003_FA5A, "R3 first write");
        reg_wr(0, 4'b0001, 32'h0000_00A5);
        expect_val(K_RD, 0, 32'h0003_FA5A, "R3 second write ignored");

        // pointers
        reg_wr(1, 4'b0001, 32'h11);
        reg_wr(4, 4'b0001, 32'h44);
        reg_wr(2, 4'b0000, 32'h22);
        expect_val(K_RD, 1, 32'h11, "R4 ptr1");
        expect_val(K_RD, 4, 32'h44, "R4 ptr4");
        expect_val(K_RD, 2, 32'h00, "R2 no lane ptr2");
        expect_val(K_RD, 5, 32'h0, "R12 unmapped");

        // R4 lock
        reg_wr(0, 4'b1000, 32'h8000_0000);
        expect_val(K_RD, 0, 32'h8003_FA5A, "R3 lock set");
        reg_wr(1, 4'b0001, 32'h99);
        expect_val(K_RD, 1, 32'h11, "R4 locked ptr");
        reg_wr(0, 4'b1000, 32'h0);
        expect_val(K_RD, 0, 32'h8003_FA5A, "R3 lock cannot clear");

        // R9 message muted (errdis=1), sse still set
        ur_pulse(1'b0, 1'b1);
        expect_val(K_MSG, 0, 32'h0, "R9 msg muted");
        expect_val(K_SSE, 0, 32'h1, "R9 sse set");
        expect_val(K_RD, 0, 32'h8003_FB5A, "R6 urd set");

        // R6 W1C
        reg_wr(0, 4'b0010, 32'h0000_FB00);
        expect_val(K_RD, 0, 32'h8003_FA5A, "R6 urd cleared");

        // R11 FLR
        reg_wr(0, 4'b0100, 32'h0001_0000);
        expect_val(K_RD, 0, 32'h8001_FA5A, "R2 errdis cleared");
        pulse_flr();
        expect_val(K_RD, 0, 32'h8000_F85A, "R11 flr fields");
        expect_val(K_SSE, 0, 32'h0, "R11 sse cleared");
        expect_val(K_RD, 1, 32'h11, "R11 ptr kept");

        // R8 message pulse
        reg_wr(0, 4'b0010, 32'h0000_FA00);
        ur_pulse(1'b0, 1'b1);
        expect_val(K_MSG, 0, 32'h1, "R8 msg high");
        expect_val(K_SSE, 0, 32'h1, "R8 sse");
        expect_val(K_RD, 0, 32'h8000_FB5A, "R6 urd primary");
        @(negedge clk);
        expect_val(K_MSG, 0, 32'h0, "R8 msg one cycle");

        // R7 sideband ignored
        pulse_flr();
        reg_wr(0, 4'b0010, 32'h0000_FA00);
        ur_pulse(1'b1, 1'b1);
        expect_val(K_MSG, 0, 32'h0, "R7 no msg");
        expect_val(K_SSE, 0, 32'h0, "R7 no sse");
        expect_val(K_RD, 0, 32'h8000_FA5A, "R7 no urd");

        // R8 serr_en low: no report
        ur_pulse(1'b0, 1'b0);
        expect_val(K_MSG, 0, 32'h0, "R8 serr_en off msg");
        expect_val(K_SSE, 0, 32'h0, "R8 serr_en off sse");

        // R6 hw set wins over W1C in the same cycle
        reg_wr(0, 4'b0010, 32'h0000_FB00);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = '0; wr_be = 4'b0010; wr_data = 32'h0000_FB00;
        ur_valid = 1'b1; ur_sideband = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; ur_valid = 1'b0;
        expect_val(K_RD, 0, 32'h8000_FB5A, "R6 set wins");

        // R5 function disable
        reg_wr(0, 4'b0010, 32'h0000_0400);
        expect_val(K_CLAIM, 0, 32'h0, "R5 claim off");
        expect_val(K_RD, 1, 32'h0, "R5 read blocked");
        reg_wr(0, 4'b0010, 32'h0000_0000);
        pulse_flr();
        expect_val(K_CLAIM, 0, 32'h0, "R5 sticky through flr");
        pulse_plat();
        expect_val(K_CLAIM, 0, 32'h1, "R5 platform reset");
        expect_val(K_RD, 0, 32'h0, "R1 cfg after plat");
        expect_val(K_RD, 4, 32'h0, "R1 ptr after plat");

        // R3 write-once reopened after platform reset
        reg_wr(0, 4'b0001, 32'h0000_0033);
        expect_val(K_RD, 0, 32'h0000_0033, "R3 reopened");
        reg_wr(3, 4'b0001, 32'h77);
        expect_val(K_RD, 3, 32'h77, "R4 unlocked write");

        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule